// File: doc/BRIEF.md
# Completion Queue with Selective Early Retirement

This block tracks in-flight instructions between decode and graduation. Decode places one instruction per cycle into the next free slot in program order, and the slot number becomes the instruction's tag. Execution units later report a finished instruction by tag. The graduation side commits up to two finished instructions per cycle and names them on its output lanes, oldest in lane 0.

A mode input selects the retirement policy. In strict mode an instruction commits only when every older live instruction has also finished. In relaxed mode a finished instruction may commit ahead of older unfinished ones, but only when none of those older unfinished ones is marked as possibly faulting or is a branch that is not yet resolved. A branch counts as resolved once it is reported finished. A flush request discards every instruction younger than a named live entry, so that decode resumes right behind it.

Slots are used as a ring. A slot freed out of order becomes a hole that is not reused until the oldest live entry moves past it. The queue reports itself full when the span from the oldest live entry to the next write slot covers all slots.

Top module: `cq_top`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_tag` is 0 and no graduation lane is valid.
- R2: Each accepted allocation (`alloc_valid` with `alloc_ready` high) receives tag `alloc_tag`, and the next tag is the previous one plus 1 modulo DEPTH. `alloc_ready` is 0 while the span from the oldest live entry to the write slot equals DEPTH, and an allocation request at that time has no effect.
- R3: A finish report (`done_valid`, `done_tag`) makes its entry eligible from the next cycle on. A report that names a slot holding no live entry has no effect.
- R4: With `relax_en` = 0, a finished entry graduates only when every older live entry has finished.
- R5: With `relax_en` = 1, a finished entry graduates when every older unfinished live entry has both its may-fault flag and its branch flag at 0.
- R6: In both modes, no entry younger than an unfinished branch entry graduates.
- R7: At most GRAD_W (2) entries graduate per cycle. The eligible entries are chosen oldest first, lanes fill from lane 0 upward, and lane 0 carries the oldest.
- R8: A graduated entry leaves the queue at the clock edge that ends its graduation cycle. When it was the oldest live entry, the freed span shows in `alloc_ready` in the next cycle.
- R9: A flush (`flush_valid`, `flush_tag` naming a live entry) removes every entry younger than `flush_tag`. The next allocation tag becomes `flush_tag` + 1 modulo DEPTH. `alloc_ready` is 0 during the flush cycle.
- R10: Holes left by out-of-order graduation are skipped. The oldest live entry, and therefore the free span, advances past them as soon as every older entry is gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| relax_en | input | 1 | 1 = relaxed retirement, 0 = strict program order |
| alloc_valid | input | 1 | Decode requests an allocation |
| alloc_may_fault | input | 1 | The new instruction may raise an exception |
| alloc_is_branch | input | 1 | The new instruction is a control transfer |
| alloc_ready | output | 1 | The allocation is accepted this cycle |
| alloc_tag | output | IW (3) | Tag assigned to the allocation this cycle |
| done_valid | input | 1 | An execution unit reports a finished entry |
| done_tag | input | IW (3) | Tag of the finished entry |
| flush_valid | input | 1 | Discard all entries younger than `flush_tag` |
| flush_tag | input | IW (3) | The youngest entry that survives the flush |
| grad_valid | output | GRAD_W (2) | Per-lane graduation strobe |
| grad_tag | output | GRAD_W*IW (6) | Per-lane graduating tag, lane g at bits [g*IW +: IW] |

## Verification
The graduation lanes are a function of the stored state only. A finish report sampled at one edge can therefore first show up on `grad_valid` in the cycle that follows that edge, never in the same cycle. `alloc_ready` reacts within the same cycle to `flush_valid`, and otherwise changes one edge after an allocation, a graduation of the oldest entry or a flush. The bench drives its inputs at the falling edge, compares every output about 1 ns later against a behavioural model that holds the live entries as a list in age order, and advances the model at the rising edge. Each output is thus checked in the cycle in which it is due.

// File: rtl/cq_pkg.sv
package cq_pkg;
   // per-entry attribute flags that decide whether an unfinished entry blocks younger ones
   typedef struct packed {
      logic may_fault;
      logic is_branch;
   } cq_flags_t;

   typedef enum logic {
      CQ_STRICT  = 1'b0,
      CQ_RELAXED = 1'b1
   } cq_mode_e;
endpackage

// File: rtl/cq_age_rotate.sv
// Rotates a slot-indexed vector so that bit k is the entry k places after base.
module cq_age_rotate #(
   parameter int DEPTH = 8,
   parameter int IW    = 3
) (
   input  logic [IW-1:0]    base,
   input  logic [DEPTH-1:0] phys,
   output logic [DEPTH-1:0] aged
);
   for (genvar k = 0; k < DEPTH; k++) begin : g_age
      logic [IW-1:0] slot;
      assign slot    = base + IW'(k);
      assign aged[k] = phys[slot];
   end
endmodule

// File: rtl/cq_grad_pick.sv
// Picks up to GRAD_W set bits, lowest (oldest) first, and reports their offsets.
module cq_grad_pick #(
   parameter int DEPTH  = 8,
   parameter int GRAD_W = 2,
   parameter int IW     = 3
) (
   input  logic [DEPTH-1:0]           ready_age,
   output logic [GRAD_W-1:0]          lane_v,
   output logic [GRAD_W-1:0][IW-1:0]  lane_off
);
   always_comb begin
      int cnt;
      lane_v   = '0;
      lane_off = '0;
      cnt      = 0;
      for (int k = 0; k < DEPTH; k++) begin
         if (ready_age[k]) begin
            for (int g = 0; g < GRAD_W; g++) begin
               if (cnt == g) begin
                  lane_v[g]   = 1'b1;
                  lane_off[g] = IW'(k);
               end
            end
            cnt = cnt + 1;
         end
      end
   end
endmodule

// File: rtl/cq_top.sv
module cq_top
   import cq_pkg::*;
#(
   parameter  int DEPTH  = 8,
   parameter  int GRAD_W = 2,
   localparam int IW     = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 relax_en,
   input  logic                 alloc_valid,
   input  logic                 alloc_may_fault,
   input  logic                 alloc_is_branch,
   output logic                 alloc_ready,
   output logic [IW-1:0]        alloc_tag,
   input  logic                 done_valid,
   input  logic [IW-1:0]        done_tag,
   input  logic                 flush_valid,
   input  logic [IW-1:0]        flush_tag,
   output logic [GRAD_W-1:0]    grad_valid,
   output logic [GRAD_W*IW-1:0] grad_tag
);
   localparam logic [IW:0] ONE_P   = (IW+1)'(1);
   localparam logic [IW:0] DEPTH_P = (IW+1)'(DEPTH);

   if (DEPTH < 2 || DEPTH != (1 << IW)) begin : g_bad_depth
      $error("cq_top: DEPTH must be a power of two of at least 2");
   end
   if (GRAD_W < 1 || GRAD_W > DEPTH) begin : g_bad_width
      $error("cq_top: GRAD_W must lie in 1..DEPTH");
   end

   // ---------------- state ----------------
   logic [DEPTH-1:0]            valid_q, done_q;
   cq_flags_t [DEPTH-1:0]       flags_q;
   logic [IW:0]                 head_q, tail_q;

   logic [DEPTH-1:0]            valid_n, done_n;
   cq_flags_t [DEPTH-1:0]       flags_n;
   logic [IW:0]                 head_n, tail_n;

   logic [DEPTH-1:0]            fault_v, br_v;
   for (genvar s = 0; s < DEPTH; s++) begin : g_flag_split
      assign fault_v[s] = flags_q[s].may_fault;
      assign br_v[s]    = flags_q[s].is_branch;
   end

   // ---------------- age-ordered view ----------------
   logic [DEPTH-1:0] valid_a, done_a, fault_a, br_a, elig_a;

   cq_age_rotate #(.DEPTH(DEPTH), .IW(IW)) u_rot_v (.base(head_q[IW-1:0]), .phys(valid_q), .aged(valid_a));
   cq_age_rotate #(.DEPTH(DEPTH), .IW(IW)) u_rot_d (.base(head_q[IW-1:0]), .phys(done_q),  .aged(done_a));
   cq_age_rotate #(.DEPTH(DEPTH), .IW(IW)) u_rot_f (.base(head_q[IW-1:0]), .phys(fault_v), .aged(fault_a));
   cq_age_rotate #(.DEPTH(DEPTH), .IW(IW)) u_rot_b (.base(head_q[IW-1:0]), .phys(br_v),    .aged(br_a));

   cq_mode_e mode;
   assign mode = cq_mode_e'(relax_en);

   // an unfinished entry blocks everything younger unless relaxed and harmless
   always_comb begin
      logic blocked;
      blocked = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         elig_a[k] = valid_a[k] & done_a[k] & ~blocked;
         if (valid_a[k] && !done_a[k] &&
             (mode == CQ_STRICT || fault_a[k] || br_a[k]))
            blocked = 1'b1;
      end
   end

   logic [GRAD_W-1:0]          lane_v;
   logic [GRAD_W-1:0][IW-1:0]  lane_off;

   cq_grad_pick #(.DEPTH(DEPTH), .GRAD_W(GRAD_W), .IW(IW)) u_pick (
      .ready_age (elig_a),
      .lane_v    (lane_v),
      .lane_off  (lane_off)
   );

   logic [GRAD_W-1:0][IW-1:0] lane_slot;
   for (genvar g = 0; g < GRAD_W; g++) begin : g_lane
      assign lane_slot[g]           = head_q[IW-1:0] + lane_off[g];
      assign grad_tag[g*IW +: IW]   = lane_slot[g];
   end
   assign grad_valid = lane_v;

   // ---------------- allocation side ----------------
   logic [IW:0] span;
   logic        full, alloc_fire;
   assign span        = tail_q - head_q;
   assign full        = (span == DEPTH_P);
   assign alloc_ready = ~full & ~flush_valid;
   assign alloc_tag   = tail_q[IW-1:0];
   assign alloc_fire  = alloc_valid & alloc_ready;

   // ---------------- next state ----------------
   always_comb begin
      logic [IW-1:0] off;
      logic [IW-1:0] s;
      logic [IW:0]   span_n;
      valid_n = valid_q;
      done_n  = done_q;
      flags_n = flags_q;
      tail_n  = tail_q;

      for (int g = 0; g < GRAD_W; g++)
         if (lane_v[g]) valid_n[lane_slot[g]] = 1'b0;

      if (done_valid && valid_q[done_tag])
         done_n[done_tag] = 1'b1;

      if (alloc_fire) begin
         valid_n[tail_q[IW-1:0]]           = 1'b1;
         done_n[tail_q[IW-1:0]]            = 1'b0;
         flags_n[tail_q[IW-1:0]].may_fault = alloc_may_fault;
         flags_n[tail_q[IW-1:0]].is_branch = alloc_is_branch;
         tail_n                            = tail_q + ONE_P;
      end

      off = flush_tag - head_q[IW-1:0];
      if (flush_valid) begin
         for (int k = 0; k < DEPTH; k++) begin
            s = head_q[IW-1:0] + IW'(k);
            if (IW'(k) > off) valid_n[s] = 1'b0;
         end
         tail_n = head_q + {1'b0, off} + ONE_P;
      end

      // oldest survivor becomes the new head; holes are skipped
      span_n = tail_n - head_q;
      head_n = tail_n;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         s = head_q[IW-1:0] + IW'(k);
         if ((IW+1)'(k) < span_n && valid_n[s])
            head_n = head_q + (IW+1)'(k);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         done_q  <= '0;
         flags_q <= '0;
         head_q  <= '0;
         tail_q  <= '0;
      end else begin
         valid_q <= valid_n;
         done_q  <= done_n;
         flags_q <= flags_n;
         head_q  <= head_n;
         tail_q  <= tail_n;
      end
   end
endmodule

// File: rtl/cq_top_chk.sv
module cq_top_chk #(
   parameter  int DEPTH  = 8,
   parameter  int GRAD_W = 2,
   localparam int IW     = $clog2(DEPTH)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 alloc_valid,
   input logic                 alloc_ready,
   input logic [IW-1:0]        alloc_tag,
   input logic                 flush_valid,
   input logic [IW-1:0]        flush_tag,
   input logic [GRAD_W-1:0]    grad_valid,
   input logic [GRAD_W*IW-1:0] grad_tag
);
   // R2: accepted allocation advances the write tag by one
   a_r2_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && alloc_ready && !flush_valid) |=> (alloc_tag == IW'($past(alloc_tag) + 1'b1)));

   // R2: with no accepted allocation and no flush the write tag holds
   a_r2_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_valid && !(alloc_valid && alloc_ready)) |=> $stable(alloc_tag));

   // R9: flush rewinds the write tag to just behind the surviving entry
   a_r9_flush_tail: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> (alloc_tag == IW'($past(flush_tag) + 1'b1)));

   // R9: no allocation is accepted while flushing
   a_r9_flush_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> !alloc_ready);

   for (genvar g = 1; g < GRAD_W; g++) begin : g_lane_chk
      // R7: lanes fill from lane 0 upward
      a_r7_lane_packed: assert property (@(posedge clk) disable iff (!rst_n)
         grad_valid[g] |-> grad_valid[g-1]);
      // R7: two lanes never name the same entry
      a_r7_tags_differ: assert property (@(posedge clk) disable iff (!rst_n)
         grad_valid[g] |-> (grad_tag[g*IW +: IW] != grad_tag[(g-1)*IW +: IW]));
   end
endmodule

bind cq_top cq_top_chk #(.DEPTH(DEPTH), .GRAD_W(GRAD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alloc_valid (alloc_valid),
   .alloc_ready (alloc_ready),
   .alloc_tag   (alloc_tag),
   .flush_valid (flush_valid),
   .flush_tag   (flush_tag),
   .grad_valid  (grad_valid),
   .grad_tag    (grad_tag)
);

// File: tb/sim_cq_top.sv
`timescale 1ns/1ps
module sim_cq_top;
   localparam int D  = 8;
   localparam int GW = 2;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic relax_en = 1'b0, alloc_valid = 1'b0, alloc_may_fault = 1'b0, alloc_is_branch = 1'b0;
   logic done_valid = 1'b0, flush_valid = 1'b0;
   logic [IW-1:0] done_tag = '0, flush_tag = '0;
   logic alloc_ready;
   logic [IW-1:0] alloc_tag;
   logic [GW-1:0] grad_valid;
   logic [GW*IW-1:0] grad_tag;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   cq_top #(.DEPTH(D), .GRAD_W(GW)) u0 (
      .clk(clk), .rst_n(rst_n), .relax_en(relax_en),
      .alloc_valid(alloc_valid), .alloc_may_fault(alloc_may_fault), .alloc_is_branch(alloc_is_branch),
      .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
      .done_valid(done_valid), .done_tag(done_tag),
      .flush_valid(flush_valid), .flush_tag(flush_tag),
      .grad_valid(grad_valid), .grad_tag(grad_tag)
   );

   // ---------- behavioural reference: live entries oldest first ----------
   typedef struct { int seq; bit done; bit fault; bit br; } ent_t;
   ent_t q[$];
   int   tail_seq = 0;

   function automatic int head_seq();
      return (q.size() > 0) ? q[0].seq : tail_seq;
   endfunction

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step(bit rx, bit av, bit af, bit ab, bit dv, int dt, bit fv, int ft, string req);
      int  gl[$];
      bit  blocked;
      bit  e_ready;
      int  fseq;
      @(negedge clk);
      relax_en = rx; alloc_valid = av; alloc_may_fault = af; alloc_is_branch = ab;
      done_valid = dv; done_tag = IW'(dt); flush_valid = fv; flush_tag = IW'(ft);
      #1;
      // expected outputs from the model
      e_ready = (tail_seq - head_seq() < D) && !fv;
      blocked = 0;
      foreach (q[i]) begin
         if (q[i].done && !blocked && gl.size() < GW) gl.push_back(i);
         if (!q[i].done && (!rx || q[i].fault || q[i].br)) blocked = 1;
      end
      check(req, "alloc_ready", int'(alloc_ready), int'(e_ready));
      if (e_ready) check(req, "alloc_tag", int'(alloc_tag), tail_seq % D);
      for (int g = 0; g < GW; g++) begin
         check(req, $sformatf("grad_valid[%0d]", g), int'(grad_valid[g]), int'(g < gl.size()));
         if (g < gl.size())
            check(req, $sformatf("grad_tag[%0d]", g), int'(grad_tag[g*IW +: IW]), q[gl[g]].seq % D);
      end
      @(posedge clk);
      // advance the model with the values present at this edge
      fseq = -1;
      if (fv) foreach (q[i]) if (q[i].seq % D == ft) fseq = q[i].seq;
      if (dv) foreach (q[i]) if (q[i].seq % D == dt) q[i].done = 1;
      for (int g = gl.size() - 1; g >= 0; g--) q.delete(gl[g]);
      if (av && e_ready) begin
         q.push_back('{seq: tail_seq, done: 0, fault: af, br: ab});
         tail_seq++;
      end
      if (fv && fseq >= 0) begin
         for (int i = q.size() - 1; i >= 0; i--) if (q[i].seq > fseq) q.delete(i);
         tail_seq = fseq + 1;
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: empty after reset
      step(0, 0,0,0, 0,0, 0,0, "R1");
      // R2: fill all slots in order; tag1 may fault, tag2 is a branch
      step(0, 1,0,0, 0,0, 0,0, "R2");
      step(0, 1,1,0, 0,0, 0,0, "R2");
      step(0, 1,0,1, 0,0, 0,0, "R2");
      for (int i = 3; i < D; i++) step(0, 1,0,0, 0,0, 0,0, "R2");
      step(0, 1,0,0, 0,0, 0,0, "R2");            // full: request ignored
      // R4: strict, younger entries finished, oldest not
      step(0, 0,0,0, 1,1, 0,0, "R4");
      step(0, 0,0,0, 1,3, 0,0, "R4");
      step(0, 0,0,0, 0,0, 0,0, "R4");
      // R5: relaxed, tag0 harmless so tag1 graduates; tag3 held by branch tag2
      step(1, 0,0,0, 0,0, 0,0, "R5");
      step(1, 0,0,0, 0,0, 0,0, "R6");
      // R7: resolving the branch releases two at once
      step(1, 0,0,0, 1,2, 0,0, "R7");
      step(1, 0,0,0, 1,4, 0,0, "R7");
      step(1, 0,0,0, 1,5, 0,0, "R7");
      step(1, 0,0,0, 1,6, 0,0, "R10");
      step(1, 1,0,0, 0,0, 0,0, "R10");           // span still full behind tag0
      // R3: report for a slot already gone has no effect
      step(1, 0,0,0, 1,4, 0,0, "R3");
      // R8: tag0 finishes, graduates, head skips the holes to tag7
      step(1, 0,0,0, 1,0, 0,0, "R8");
      step(1, 0,0,0, 0,0, 0,0, "R8");
      step(1, 1,0,0, 0,0, 0,0, "R8");
      step(1, 1,0,0, 0,0, 0,0, "R8");
      // R9: flush behind tag7 drops tags 0 and 1
      step(1, 1,0,0, 0,0, 1,7, "R9");
      step(1, 1,0,0, 0,0, 0,0, "R9");
      step(0, 0,0,0, 1,7, 0,0, "R9");
      step(0, 0,0,0, 1,0, 0,0, "R4");
      step(0, 0,0,0, 0,0, 0,0, "R4");
      // mixed traffic
      for (int c = 0; c < 4000; c++) begin
         bit rx, av, af, ab, dv, fv;
         int dt, ft;
         rx = ((c / 250) % 2) == 1;
         av = ($urandom % 3) != 0;
         af = ($urandom % 4) == 0;
         ab = ($urandom % 5) == 0;
         dv = ($urandom % 3) != 0;
         dt = $urandom % D;
         if (q.size() > 0 && ($urandom % 4) != 0) dt = q[$urandom % q.size()].seq % D;
         fv = (q.size() > 0) && (($urandom % 40) == 0);
         ft = (q.size() > 0) ? q[$urandom % q.size()].seq % D : 0;
         step(rx, av, af, ab, dv, dt, fv, ft, rx ? "R5" : "R4");
      end
      summary();
   end
endmodule